// File: doc/BRIEF.md
# Radix-4 Booth Array Multiplier

A signed multiplier for two 12-bit two's-complement operands that returns the full 24-bit two's-complement product. The multiplier operand is recoded into six radix-4 signed digits. Each digit picks zero, the multiplicand, or twice the multiplicand, negated when the digit is negative. The rows are summed by a linear chain of carry-save rows and then by a ripple carry-propagate adder. All operand bits enter in parallel and the whole array settles within one clock period.

The product is registered, so it appears on the output one clock edge after the operands are presented. An optional input register, chosen by a parameter, adds a second cycle of latency. Sign extension of the partial products is reduced to two or three constant-like bits per row. Negation is done by inverting the selected bits and injecting a separate add-one term.

Top module: `radix4_array_mul`

## Requirements
- R1: With `IN_REG` = 0, `prod` at a clock edge equals the signed product of `op_a` and `op_b` sampled at the previous edge, as a 24-bit two's-complement value.
- R2: While `rst_n` is low, `prod` reads zero. The reset is asynchronous and active low.
- R3: Digit d is recoded from the three multiplier bits at positions 2d+1, 2d and 2d-1 as -2*b[2d+1] + b[2d] + b[2d-1]. At most one of the x1 and x2 selects is active, and the negate flag is set only for a nonzero digit.
- R4: The lowest digit uses an implicit 0 in the bit position below `op_b[0]`. Odd multipliers, for example 1 and -1, give exact products.
- R5: A digit of magnitude 2 selects the multiplicand shifted left by one. A negative digit inverts the 13-bit selected row. Its +1 is injected at that row's least significant weight, carried in the following operand's column 2d, and the last row's +1 goes in a separate operand.
- R6: Sign-generate extension is used. Row 0 carries the bits {~e, e, e} above its 13 bits. Middle rows carry {1, ~e}. The top row carries ~e only. The result equals full sign extension modulo 2^24.
- R7: Seven operands (six rows and one add-one vector) are reduced by five 3:2 carry-save rows in series. In each row, sum + carry equals the sum of its three inputs modulo 2^24.
- R8: A 24-bit ripple carry-propagate adder returns the sum of the final sum and carry vectors modulo 2^24.
- R9: The extreme operands give exact results. For example, -2048 * -2048 = 4194304, -2048 * 2047 = -4192256, and 2047 * 2047 = 4190209.
- R10: With `IN_REG` = 1, the same product appears two clock edges after the operands are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 12 | Multiplicand, two's complement |
| op_b | input | 12 | Multiplier, two's complement, Booth recoded |
| prod | output | 24 | Registered product, two's complement |

## Verification
Within one product, a negated digit's add-one term lands in the same column as the next row's shifted or doubled bits. In the same cycle, the sign-generate constants of adjacent rows collide in the upper columns. The bench provokes this with every multiplier value against the most negative, the most positive and an alternating multiplicand, with every multiplicand against alternating and extreme multipliers, and with all extreme pairs. Each result is judged against a plain signed multiply computed in the bench, for both the one-cycle and the two-cycle variants.

// File: rtl/mul_pkg.sv
package mul_pkg;

    // One recoded radix-4 digit: magnitude select plus sign
    typedef struct packed {
        logic neg;
        logic two;
        logic one;
    } bdigit_t;

endpackage

// File: rtl/booth_enc.sv
module booth_enc
    import mul_pkg::*;
(
    input  logic [2:0] grp,
    output bdigit_t    dig
);

    always_comb begin
        dig.one = grp[1] ^ grp[0];
        dig.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
        dig.neg = grp[2] & ~(grp[1] & grp[0]);
    end

    // R3: never both magnitudes, negate only with a nonzero magnitude
    always_comb begin
        assert_digit_onehot_R3: assert ($onehot0({dig.one, dig.two}))
            else $error("booth digit selects both magnitudes");
        assert_neg_nonzero_R3: assert (!dig.neg || dig.one || dig.two)
            else $error("negate flag on a zero digit");
    end

endmodule

// File: rtl/pp_row.sv
module pp_row
    import mul_pkg::*;
#(
    parameter int W   = 12,
    parameter int ROW = 0,
    parameter int ND  = W / 2
) (
    input  logic [W-1:0]   a,
    input  bdigit_t        dig,
    output logic [2*W-1:0] row
);

    localparam int PW  = 2 * W;
    localparam int LSB = 2 * ROW;

    logic [W:0] mag;
    logic [W:0] sel;
    logic       e;

    // R5: magnitude select and bitwise inversion for negative digits
    always_comb begin
        if (dig.two)      mag = {a, 1'b0};
        else if (dig.one) mag = {a[W-1], a};
        else              mag = '0;
        sel = mag ^ {(W+1){dig.neg}};
        e   = sel[W];
    end

    // R6: sign-generate extension, variant chosen by row position
    generate
        if (ROW == 0) begin : g_first
            always_comb begin
                row              = '0;
                row[W:0]         = sel;
                row[W+3:W+1]     = {~e, e, e};
            end
        end else if (ROW == ND - 1) begin : g_last
            always_comb begin
                row              = '0;
                row[LSB +: W+1]  = sel;
                row[PW-1]        = ~e;
            end
        end else begin : g_mid
            always_comb begin
                row                  = '0;
                row[LSB +: W+1]      = sel;
                row[LSB+W+2 -: 2]    = {1'b1, ~e};
            end
        end
    endgenerate

endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int PW = 24
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    input  logic [PW-1:0] z,
    output logic [PW-1:0] s,
    output logic [PW-1:0] c
);

    always_comb begin
        s = x ^ y ^ z;
        c = {(x[PW-2:0] & y[PW-2:0]) | (x[PW-2:0] & z[PW-2:0]) |
             (y[PW-2:0] & z[PW-2:0]), 1'b0};
    end

    // R7: 3:2 compression keeps the arithmetic sum
    always_comb begin
        assert_csa_sum_R7: assert (PW'(s + c) == PW'(x + y + z))
            else $error("carry-save row lost value");
    end

endmodule

// File: rtl/ripple_cpa.sv
module ripple_cpa #(
    parameter int PW = 24
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    output logic [PW-1:0] sum
);

    logic [PW-1:0] cy;

    assign cy[0] = 1'b0;

    generate
        for (genvar i = 0; i < PW; i++) begin : g_bit
            assign sum[i] = x[i] ^ y[i] ^ cy[i];
            if (i < PW - 1) begin : g_cy
                assign cy[i+1] = (x[i] & y[i]) | (x[i] & cy[i]) | (y[i] & cy[i]);
            end
        end
    endgenerate

    // R8: ripple adder result
    always_comb begin
        assert_cpa_sum_R8: assert (sum == PW'(x + y))
            else $error("carry-propagate adder mismatch");
    end

endmodule

// File: rtl/radix4_array_mul.sv
module radix4_array_mul
    import mul_pkg::*;
#(
    parameter int W      = 12,
    parameter bit IN_REG = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] prod
);

    localparam int PW   = 2 * W;
    localparam int ND   = W / 2;
    localparam int NOPS = ND + 1;
    localparam int NCSA = NOPS - 2;

    logic [W-1:0] a_s;
    logic [W-1:0] b_s;

    // Optional operand register
    generate
        if (IN_REG) begin : g_inreg
            typedef struct packed {
                logic [W-1:0] a;
                logic [W-1:0] b;
            } in_t;
            in_t in_d, in_q;

            always_comb begin
                in_d.a = op_a;
                in_d.b = op_b;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) in_q <= '0;
                else        in_q <= in_d;
            end

            assign a_s = in_q.a;
            assign b_s = in_q.b;
        end else begin : g_direct
            assign a_s = op_a;
            assign b_s = op_b;
        end
    endgenerate

    // R4: implicit zero below the multiplier LSB
    logic [W:0] b_ext;
    assign b_ext = {b_s, 1'b0};

    bdigit_t       digs [ND];
    logic [PW-1:0] rows [ND];
    logic [PW-1:0] ops  [NOPS];

    generate
        for (genvar d = 0; d < ND; d++) begin : g_digit
            booth_enc u_enc (
                .grp (b_ext[2*d +: 3]),
                .dig (digs[d])
            );

            pp_row #(.W(W), .ROW(d), .ND(ND)) u_row (
                .a   (a_s),
                .dig (digs[d]),
                .row (rows[d])
            );

            // R5: add-one of the previous row rides in this row's free column
            if (d == 0) begin : g_op0
                assign ops[d] = rows[d];
            end else begin : g_opn
                assign ops[d] = rows[d] | (PW'(digs[d-1].neg) << (2*(d-1)));
            end
        end
    endgenerate

    assign ops[ND] = PW'(digs[ND-1].neg) << (2*(ND-1));

    // R7: linear carry-save chain
    logic [PW-1:0] s_acc [NCSA+1];
    logic [PW-1:0] c_acc [NCSA+1];

    assign s_acc[0] = ops[0];
    assign c_acc[0] = ops[1];

    generate
        for (genvar k = 0; k < NCSA; k++) begin : g_csa
            csa_row #(.PW(PW)) u_csa (
                .x (s_acc[k]),
                .y (c_acc[k]),
                .z (ops[k+2]),
                .s (s_acc[k+1]),
                .c (c_acc[k+1])
            );
        end
    endgenerate

    logic [PW-1:0] sum_w;

    ripple_cpa #(.PW(PW)) u_cpa (
        .x   (s_acc[NCSA]),
        .y   (c_acc[NCSA]),
        .sum (sum_w)
    );

    // Output register, two-process
    typedef struct packed {
        logic [PW-1:0] prod;
        logic          armed;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d.prod  = sum_w;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod = st_q.prod;

    // R1: registered product matches a signed multiply of the staged operands
    assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> prod == $past(PW'($signed(a_s)) * PW'($signed(b_s))))
        else $error("product mismatch");

    // R2: reset holds the product at zero
    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |-> prod == '0)
        else $error("product not cleared in reset");

endmodule

// File: tb/radix4_array_mul_bench.sv
`timescale 1ns/1ps
module radix4_array_mul_bench;

    localparam int W  = 12;
    localparam int PW = 2 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic signed [W-1:0] op_a = '0;
    logic signed [W-1:0] op_b = '0;
    logic [PW-1:0] prod;
    logic [PW-1:0] prod_r;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    radix4_array_mul #(.W(W), .IN_REG(1'b0)) u_radix4_array_mul (
        .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b), .prod (prod)
    );

    radix4_array_mul #(.W(W), .IN_REG(1'b1)) u_radix4_array_mul_inreg (
        .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b), .prod (prod_r)
    );

    logic [PW-1:0] e1, e2;
    string         t1, t2;
    bit            hv1 = 1'b0, hv2 = 1'b0;

    task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] exp_v,
                         input string tag);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag,
                     $signed(act), $signed(exp_v));
        end
    endtask

    // One operand pair per cycle; results checked one and two cycles later
    task automatic step(input logic signed [W-1:0] x, input logic signed [W-1:0] y,
                        input string tag);
        @(negedge clk);
        if (hv1) check(prod, e1, t1);
        if (hv2) check(prod_r, e2, {t2, " R10"});
        e2  = e1;  t2 = t1;  hv2 = hv1;
        e1  = PW'(x) * PW'(y);
        t1  = tag; hv1 = 1'b1;
        op_a = x;
        op_b = y;
    endtask

    logic signed [W-1:0] corners [5];

    initial begin
        corners[0] = 12'sd0;
        corners[1] = 12'sd1;
        corners[2] = -12'sd1;
        corners[3] = -12'sd2048;
        corners[4] = 12'sd2047;

        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(prod, '0, "R2 reset");
        check(prod_r, '0, "R2 reset inreg");
        rst_n = 1'b1;

        // R9: every extreme pair
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                step(corners[i], corners[j], "R9 R4");

        // R3 R4 R5: every multiplier value against three multiplicands
        for (int v = 0; v < 4096; v++) step(-12'sd2048, 12'(v), "R3 R4 R5");
        for (int v = 0; v < 4096; v++) step(12'sd2047,  12'(v), "R3 R4 R5");
        for (int v = 0; v < 4096; v++) step(12'sh555,   12'(v), "R3 R5 R6");

        // R5 R6: every multiplicand against alternating and extreme multipliers
        for (int v = 0; v < 4096; v++) step(12'(v), 12'shAAA, "R5 R6");
        for (int v = 0; v < 4096; v++) step(12'(v), -12'sd2048, "R5 R6");
        for (int v = 0; v < 4096; v++) step(12'(v), 12'sd2047, "R5 R6");

        // R1 R7 R8: random pairs
        for (int n = 0; n < 100000; n++)
            step(12'($urandom), 12'($urandom), "R1 R7 R8");

        step('0, '0, "R1 flush");
        step('0, '0, "R1 flush");
        step('0, '0, "R1 flush");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule